// File: doc/BRIEF.md
# FM Synthesizer Interval Timer Pair

This block provides the two programmable interval timers of an FM sound generator. Software loads a reload value and a control word through a byte-wide register write port. A one-cycle `period_tick` input marks the start of each operator update period, and the timers advance only on those ticks. Timer A has a 10-bit reload value and steps once per period. Timer B has an 8-bit reload value and steps once every sixteen periods.

When an enabled counter is found at zero on a step, it reloads. If its flag enable is set, it also raises an overflow flag in the status byte. Software clears the flags through one-shot bits in the control word. Every data write raises a busy bit for a fixed window of clock cycles. The status byte is a plain registered output, so reading it has no side effects.

Top module: `fm_timer_pair`

## Requirements
- R1: Synchronous active-high `rst` clears the status byte, both counters, both reload values, the control bits and the divide-by-16 prescaler.
- R2: Address 0 writes data bits 7..0 into Timer A reload bits 9..2, and address 1 writes data bits 1..0 into reload bits 1..0. Each write keeps the other part. With reload value N and the flag enabled, consecutive Timer A flag events are N+1 ticks apart.
- R3: Address 2 writes the 8-bit Timer B reload value. Timer B steps only on every 16th tick, so with reload value N its flag events are 16·(N+1) ticks apart.
- R4: On a step, an enabled counter holding zero reloads, and any other enabled counter decrements. The flag (status bit 0 for A, bit 1 for B) is set only if the timer's flag enable is set. Control (address 3) bit 2 is the flag enable for A and bit 3 is the flag enable for B.
- R5: A timer whose enable bit is 0 neither counts nor sets its flag. Control bit 0 enables A and bit 1 enables B.
- R6: A control write with bit 4 set clears Timer A's flag, and bit 5 clears Timer B's flag. The other flag is unaffected, and the clear bits are not stored.
- R7: If a flag is set and cleared in the same cycle, the flag ends up set.
- R8: Every data write sets status bit 7 (busy) for exactly 17 clock cycles. A write made while busy restarts the full window.
- R9: Status bits 6..2 always read 0.
- R10: Timer B's prescaler counts ticks whether or not Timer A is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_tick | input | 1 | One-cycle pulse at the start of each update period |
| wr_en | input | 1 | Data write strobe |
| wr_addr | input | 2 | Register select: 0 A high, 1 A low, 2 B reload, 3 control |
| wr_data | input | 8 | Write data |
| status | output | 8 | bit0 A flag, bit1 B flag, bit7 busy |

## Verification
Two functions can land in the same cycle: a counter expiring with its flag enabled, and a control write that clears that same flag. The bench sets a Timer A reload of zero so that every tick expires the counter. It then raises `period_tick` and the clearing control write together on one edge, and expects the flag to read 1 afterwards. A following clear-only write must bring the flag to 0.

// File: rtl/fm_timer_pkg.sv
package fm_timer_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_A_HI = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_A_LO = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_B    = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd3;

  localparam int CTL_RUN_A = 0;
  localparam int CTL_RUN_B = 1;
  localparam int CTL_FEN_A = 2;
  localparam int CTL_FEN_B = 3;
  localparam int CTL_CLR_A = 4;
  localparam int CTL_CLR_B = 5;

  localparam int ST_FLAG_A = 0;
  localparam int ST_FLAG_B = 1;
  localparam int ST_BUSY   = 7;

  typedef struct packed {
    logic run_a;
    logic run_b;
    logic fen_a;
    logic fen_b;
  } tmr_ctrl_t;
endpackage

// File: rtl/fm_timer_regs.sv
module fm_timer_regs
  import fm_timer_pkg::*;
#(
  parameter int A_W    = 10,
  parameter int A_LO_W = 2,
  parameter int B_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [A_W-1:0]    reload_a,
  output logic [B_W-1:0]    reload_b,
  output tmr_ctrl_t         ctrl,
  output logic              clr_a,
  output logic              clr_b
);
  localparam int A_HI_W = A_W - A_LO_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_a <= '0;
      reload_b <= '0;
      ctrl     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_A_HI: reload_a[A_W-1:A_LO_W] <= wr_data[A_HI_W-1:0];
        ADR_A_LO: reload_a[A_LO_W-1:0]   <= wr_data[A_LO_W-1:0];
        ADR_B:    reload_b               <= wr_data[B_W-1:0];
        default: begin
          ctrl.run_a <= wr_data[CTL_RUN_A];
          ctrl.run_b <= wr_data[CTL_RUN_B];
          ctrl.fen_a <= wr_data[CTL_FEN_A];
          ctrl.fen_b <= wr_data[CTL_FEN_B];
        end
      endcase
    end
  end

  always_comb begin
    clr_a = wr_en && (wr_addr == ADR_CTRL) && wr_data[CTL_CLR_A];
    clr_b = wr_en && (wr_addr == ADR_CTRL) && wr_data[CTL_CLR_B];
  end

  AST_A_LO_KEPT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADR_A_HI) |=> reload_a[A_LO_W-1:0] == $past(reload_a[A_LO_W-1:0])); // R2
  AST_A_HI_KEPT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADR_A_LO) |=> reload_a[A_W-1:A_LO_W] == $past(reload_a[A_W-1:A_LO_W])); // R2
endmodule

// File: rtl/fm_timer_down.sv
module fm_timer_down #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] reload,
  output logic         expire
);
  logic [W-1:0] cnt;

  assign expire = step && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (expire)  cnt <= reload;
    else if (step)    cnt <= cnt - 1'b1;
  end

  AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    (step && cnt == '0) |=> cnt == $past(reload)); // R4
  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (step && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt)); // R5
endmodule

// File: rtl/fm_timer_busy.sv
module fm_timer_busy #(
  parameter int BUSY_CYCLES = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
      busy <= 1'b0;
    end else if (wr_en) begin
      left <= CNT_W'(BUSY_CYCLES - 1);
      busy <= 1'b1;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end else begin
      busy <= 1'b0;
    end
  end

  AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> busy); // R8
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && left != '0 && !wr_en) |=> busy); // R8
endmodule

// File: rtl/fm_timer_pair.sv
module fm_timer_pair
  import fm_timer_pkg::*;
#(
  parameter int A_W         = 10,
  parameter int A_LO_W      = 2,
  parameter int B_W         = 8,
  parameter int B_DIV_LOG2  = 4,
  parameter int BUSY_CYCLES = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              period_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] status
);
  logic [A_W-1:0] reload_a;
  logic [B_W-1:0] reload_b;
  tmr_ctrl_t      ctrl;
  logic           clr_a, clr_b;
  logic           exp_a, exp_b;
  logic           flag_a, flag_b, busy;
  logic [B_DIV_LOG2-1:0] pre;
  logic           step_a, step_b;

  fm_timer_regs #(.A_W(A_W), .A_LO_W(A_LO_W), .B_W(B_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .reload_a(reload_a), .reload_b(reload_b), .ctrl(ctrl),
    .clr_a(clr_a), .clr_b(clr_b)
  );

  // Timer B prescaler runs on every tick, independent of enables.
  always_ff @(posedge clk) begin
    if (rst)              pre <= '0;
    else if (period_tick) pre <= pre + 1'b1;
  end

  assign step_a = period_tick && ctrl.run_a;
  assign step_b = period_tick && (pre == '0) && ctrl.run_b;

  fm_timer_down #(.W(A_W)) u_tmr_a (
    .clk(clk), .rst(rst), .step(step_a), .reload(reload_a), .expire(exp_a)
  );
  fm_timer_down #(.W(B_W)) u_tmr_b (
    .clk(clk), .rst(rst), .step(step_b), .reload(reload_b), .expire(exp_b)
  );

  fm_timer_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .wr_en(wr_en), .busy(busy)
  );

  // Set has priority over clear so an overflow is never lost.
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_a <= 1'b0;
      flag_b <= 1'b0;
    end else begin
      if (exp_a && ctrl.fen_a) flag_a <= 1'b1;
      else if (clr_a)          flag_a <= 1'b0;
      if (exp_b && ctrl.fen_b) flag_b <= 1'b1;
      else if (clr_b)          flag_b <= 1'b0;
    end
  end

  always_comb begin
    status            = '0;
    status[ST_FLAG_A] = flag_a;
    status[ST_FLAG_B] = flag_b;
    status[ST_BUSY]   = busy;
  end

  AST_SET_WINS_A: assert property (@(posedge clk) disable iff (rst)
    (exp_a && ctrl.fen_a && clr_a) |=> status[ST_FLAG_A]); // R7
  AST_CLEAR_A: assert property (@(posedge clk) disable iff (rst)
    (clr_a && !exp_a) |=> !status[ST_FLAG_A]); // R6
  AST_NO_FLAG_IDLE_A: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run_a && !status[ST_FLAG_A]) |=> !status[ST_FLAG_A]); // R5
  AST_PRE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (period_tick && pre == '1) |=> pre == '0); // R10
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    status[6:2] == 5'd0); // R9
endmodule

// File: tb/tb_fm_timer_pair.sv
module tb_fm_timer_pair;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       period_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] status;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [1:0] A_HI = 2'd0, A_LO = 2'd1, B_RL = 2'd2, CTL = 2'd3;

  fm_timer_pair dut (
    .clk(clk), .rst(rst), .period_tick(period_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .status(status)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; period_tick = 1'b0; wr_en = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); period_tick = 1'b1;
      @(negedge clk); period_tick = 1'b0;
    end
  endtask

  // Clear the flag, then count ticks until it is raised again.
  task automatic measure(input int bitpos, input logic [7:0] ctl, output int n);
    wr(CTL, ctl | (bitpos == 0 ? 8'h10 : 8'h20));
    n = 0;
    while (n < 5000) begin
      tick(1);
      n++;
      if (status[bitpos]) break;
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 status after reset", status, 0);
    wr(A_HI, 8'h00); wr(CTL, 8'h0F); tick(2);
    do_reset();
    check("R1 status cleared by reset", status, 0);
  endtask

  task automatic t_timer_a();
    int n;
    do_reset();
    wr(A_HI, 8'h00); wr(A_LO, 8'h03); wr(CTL, 8'h05);
    measure(0, 8'h05, n); measure(0, 8'h05, n);
    check("R2 period N=3", n, 4);
    wr(A_HI, 8'h02);
    measure(0, 8'h05, n); measure(0, 8'h05, n);
    check("R2 high write keeps low bits N=11", n, 12);
    wr(A_LO, 8'h00);
    measure(0, 8'h05, n); measure(0, 8'h05, n);
    check("R2 low write keeps high bits N=8", n, 9);
    wr(A_HI, 8'hFF); wr(A_LO, 8'h03);
    measure(0, 8'h05, n); measure(0, 8'h05, n);
    check("R2 full-scale N=1023", n, 1024);
  endtask

  task automatic t_timer_b();
    int n;
    do_reset();
    wr(B_RL, 8'h02); wr(CTL, 8'h0A);
    measure(1, 8'h0A, n); measure(1, 8'h0A, n);
    check("R3 B period N=2", n, 48);
    check("R10 B runs with A disabled, A flag stays low", status[0], 0);
    wr(B_RL, 8'h00);
    measure(1, 8'h0A, n); measure(1, 8'h0A, n);
    check("R3 B period N=0", n, 16);
  endtask

  task automatic t_flag_enable();
    do_reset();
    wr(CTL, 8'h01); tick(5);
    check("R4 no flag without flag enable", status[0], 0);
    wr(CTL, 8'h05); tick(1);
    check("R4 zero counter sets flag on step", status[0], 1);
  endtask

  task automatic t_disabled();
    do_reset();
    wr(CTL, 8'h0C); tick(40);
    check("R5 disabled timers raise no flags", status[1:0], 0);
  endtask

  task automatic t_clear();
    do_reset();
    wr(CTL, 8'h0F); tick(16);
    check("R6 both flags set", status[1:0], 3);
    wr(CTL, 8'h1F);
    check("R6 clear A only", status[1:0], 2);
    wr(CTL, 8'h2F);
    check("R6 clear B", status[1:0], 0);
    tick(1);
    check("R6 clear bits not stored, A flags again", status[0], 1);
  endtask

  task automatic t_collide();
    do_reset();
    wr(CTL, 8'h05);
    @(negedge clk); period_tick = 1'b1; wr_en = 1'b1; wr_addr = CTL; wr_data = 8'h15;
    @(negedge clk); period_tick = 1'b0; wr_en = 1'b0;
    check("R7 set wins over clear", status[0], 1);
    wr(CTL, 8'h15);
    check("R7 clear alone clears", status[0], 0);
  endtask

  task automatic t_busy();
    int hi;
    do_reset();
    wr(B_RL, 8'h00);
    hi = 0;
    for (int i = 0; i < 17; i++) begin
      if (status[7]) hi++;
      @(negedge clk);
    end
    check("R8 busy high for 17 cycles", hi, 17);
    check("R8 busy low after window", status[7], 0);
    wr(B_RL, 8'h00);
    repeat (9) @(negedge clk);
    wr(B_RL, 8'h00);
    hi = 0;
    for (int i = 0; i < 17; i++) begin
      if (status[7]) hi++;
      @(negedge clk);
    end
    check("R8 rewrite restarts busy window", hi, 17);
    check("R8 busy low after restarted window", status[7], 0);
    check("R9 spare status bits zero", status[6:2], 0);
  endtask

  initial begin
    t_reset();
    t_timer_a();
    t_timer_b();
    t_flag_enable();
    t_disabled();
    t_clear();
    t_collide();
    t_busy();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule